// File: doc/BRIEF.md
# Register-Access Command/Data FIFO Bridge

This block gives a host processor access to a private bank of 128 sixteen-bit registers. It does so through two queues rather than a direct address map. The host writes 32-bit command words to one address. Each word is decoded into a register write, a register read or a no-op, and it takes effect in the cycle it is written, so the command queue never holds anything. Results of reads and no-ops come back through a 15-entry read-data queue. Each result arrives one command late: every read or no-op pushes the value that the previous read or no-op produced.

Around the two queues sit a small set of word registers: configuration, interrupt status, interrupt mask, status and control. The block has one level interrupt output. Eight alarm pins, the top one being over-temperature, raise interrupt status bits on their rising edges. A control bit acts as a held channel reset. While it is 1, the queues, the pending result and the register bank stay cleared, and commands are ignored.

Top module: `regbank_fifo_bridge`

## Requirements
- R1: After reset the host reads these values: config 0x0000_1114, interrupt status 0x200, mask 0x3FF, status 0x500, control 0x10. The irq output is 0.
- R2: Config (byte offset 0x00) keeps only bits 31, 23:16, 13:12, 9:8 and 4:0; all other bits read 0. Bits 19:16 hold the data-queue threshold.
- R3: A command word (offset 0x10) holds its opcode in 29:26, the register number in 22:16 and the data in 15:0. Opcode 2 writes the data into the bank. Opcodes 3 to 15 change neither the bank nor the data queue.
- R4: Opcode 1 (read) and opcode 0 (no-op) push the pending result into the data queue. The pending result then becomes the addressed register for a read, or zero for a no-op.
- R5: The data queue holds 15 entries and drops pushes while full. A read of offset 0x14 pops the oldest entry, and a read while the queue is empty returns 0.
- R6: Status (0x0C) shows the entry count in 15:12, command-full 11 (always 0), command-empty 10 (always 1), data-full 9, data-empty 8 and the sampled alarm levels in 7:0.
- R7: Writing 1 to an interrupt status bit (0x04) clears it. The mask (0x08) keeps bits 9:0 and reads the rest as 0. irq is the OR of status bits whose mask bit is 0.
- R8: Interrupt status bit 8 sets whenever the entry count exceeds the config threshold, including in the cycle after a clear.
- R9: Interrupt status bit 9 (command queue below threshold) sets in every cycle. A read issued right after a clear shows it as 0, and the read after that shows it as 1.
- R10: A rising edge on alarm pin k sets status bit k (0 to 6), and a rising edge on over-temperature sets bit 7. A pin that stays high does not set its bit again after a clear.
- R11: Control (0x18) bit 4 is a held channel reset, and all other control bits read 0. While it is 1, the queue is empty, the pending result and the bank are cleared, and commands are ignored.
- R12: Writes to 0x0C, 0x14, 0x1C and misaligned addresses are ignored. Reads of 0x10, 0x1C and misaligned addresses return 0.
- R13: Read data is registered and appears on the clock edge that samples the read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| alarm_in | input | N_ALARM | Alarm pins, rising-edge sensitive |
| overtemp_in | input | 1 | Over-temperature pin, rising-edge sensitive |
| irq | output | 1 | Level interrupt |

## Verification
The bench writes every one of the 128 bank registers and reads each back through the one-behind queue. A design that pushed the current result instead of the previous one would be off by one register on every pop. It fills the queue past 15 entries, then drains it and pops once more. A design that wrapped, overwrote entries or underflowed its count would show a wrong count or a wrong order. It clears both level interrupt bits while their conditions still hold and reads twice. A design that treated them as edges would leave them at 0, and one that ignored the clear would never show the 0. It also holds the channel reset across pending data, issues commands with unknown opcodes and writes to read-only addresses. A leaky design would show stale bank contents or a changed queue count after any of these.

// File: rtl/rfb_pkg.sv
`timescale 1ns/1ps
package rfb_pkg;
   // word index = byte address [4:2]
   localparam logic [2:0] IDX_CFG  = 3'd0;
   localparam logic [2:0] IDX_ISTS = 3'd1;
   localparam logic [2:0] IDX_IMSK = 3'd2;
   localparam logic [2:0] IDX_STAT = 3'd3;
   localparam logic [2:0] IDX_CMD  = 3'd4;
   localparam logic [2:0] IDX_DATA = 3'd5;
   localparam logic [2:0] IDX_CTRL = 3'd6;

   localparam logic [3:0] OP_NOP = 4'd0;
   localparam logic [3:0] OP_RD  = 4'd1;
   localparam logic [3:0] OP_WR  = 4'd2;

   localparam logic [31:0] CFG_RESET = 32'h0000_1114;
   localparam logic [31:0] CFG_KEEP  = 32'h80FF_331F;
   localparam int          CTRL_RST_BIT = 4;
   localparam int          ISTS_W   = 10;
   localparam logic [ISTS_W-1:0] ISTS_RESET = 10'h200;

   typedef struct packed {
      logic [3:0]  op;
      logic [6:0]  reg_no;
      logic [15:0] data;
   } cmd_t;

   function automatic cmd_t cmd_decode(input logic [31:0] w);
      cmd_t c;
      c.op     = w[29:26];
      c.reg_no = w[22:16];
      c.data   = w[15:0];
      return c;
   endfunction
endpackage

// File: rtl/rfb_data_fifo.sv
`timescale 1ns/1ps
module rfb_data_fifo #(
   parameter int DEPTH = 15,
   parameter int DW    = 16,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   if (DEPTH < 2) begin : g_depth_bad
      $error("rfb_data_fifo: DEPTH must be at least 2");
   end

   function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = mem[rd_ptr];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) mem[g] <= '0;
         else if (do_push && wr_ptr == PW'(g)) mem[g] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= ptr_inc(wr_ptr);
         if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/rfb_reg_bank.sv
`timescale 1ns/1ps
module rfb_reg_bank #(
   parameter int AW = 7,
   parameter int DW = 16,
   localparam int NREG = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] bank [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n || clr)                    bank[g] <= '0;
         else if (we && waddr == AW'(g))       bank[g] <= wdata;
      end
   end

   assign rdata = bank[raddr];
endmodule

// File: rtl/rfb_irq_unit.sv
`timescale 1ns/1ps
module rfb_irq_unit
   import rfb_pkg::*;
#(
   parameter int N_SRC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_raw,
   input  logic [1:0]        lvl_set,
   input  logic              clr_we,
   input  logic [ISTS_W-1:0] clr_bits,
   input  logic              msk_we,
   input  logic [ISTS_W-1:0] msk_data,
   output logic [ISTS_W-1:0] sts,
   output logic [ISTS_W-1:0] msk,
   output logic [N_SRC-1:0]  src_smp,
   output logic              irq
);
   logic [ISTS_W-1:0] clr_v, set_v;
   logic [N_SRC-1:0]  rise;

   if (N_SRC != ISTS_W - 2) begin : g_src_bad
      $error("rfb_irq_unit: N_SRC must leave two level bits on top");
   end

   assign rise  = src_raw & ~src_smp;
   assign clr_v = clr_we ? clr_bits : '0;
   // level sources lose to a same-cycle clear, edge sources win
   assign set_v = {lvl_set & ~clr_v[ISTS_W-1 -: 2], rise};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts     <= ISTS_RESET;
         msk     <= '1;
         src_smp <= '0;
      end else begin
         sts     <= (sts & ~clr_v) | set_v;
         src_smp <= src_raw;
         if (msk_we) msk <= msk_data;
      end
   end

   assign irq = |(sts & ~msk);
endmodule

// File: rtl/regbank_fifo_bridge.sv
`timescale 1ns/1ps
module regbank_fifo_bridge
   import rfb_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int REG_AW     = 7,
   parameter int REG_DW     = 16,
   parameter int FIFO_DEPTH = 15,
   parameter int N_ALARM    = 7,
   localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic [N_ALARM-1:0] alarm_in,
   input  logic              overtemp_in,
   output logic              irq
);
   if (ADDR_W < 5)                      begin : g_aw_bad  $error("ADDR_W must be >= 5"); end
   if (FIFO_DEPTH < 2 || FIFO_DEPTH > 15) begin : g_fd_bad $error("FIFO_DEPTH out of 2..15"); end
   if (REG_AW > 7 || REG_AW < 1)        begin : g_ra_bad  $error("REG_AW out of 1..7"); end
   if (REG_DW > 16 || REG_DW < 1)       begin : g_rd_bad  $error("REG_DW out of 1..16"); end
   if (N_ALARM > 7 || N_ALARM < 1)      begin : g_al_bad  $error("N_ALARM out of 1..7"); end

   // ---------------- address decode
   logic       hi_ok, hit;
   logic [2:0] idx;
   if (ADDR_W > 5) begin : g_hi_chk
      assign hi_ok = ~|bus_addr[ADDR_W-1:5];
   end else begin : g_hi_none
      assign hi_ok = 1'b1;
   end
   assign hit = hi_ok && (bus_addr[1:0] == 2'b00);
   assign idx = bus_addr[4:2];

   // ---------------- direct registers
   logic [31:0] cfg_q;
   logic        ctrl_rst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= CFG_RESET;
         ctrl_rst <= 1'b1;
      end else if (bus_wr && hit) begin
         if (idx == IDX_CFG)  cfg_q    <= bus_wdata & CFG_KEEP;
         if (idx == IDX_CTRL) ctrl_rst <= bus_wdata[CTRL_RST_BIT];
      end
   end

   // ---------------- command decode
   cmd_t cmd;
   logic cmd_we, is_rd, is_nop, is_wr;
   assign cmd    = cmd_decode(bus_wdata);
   assign cmd_we = bus_wr && hit && (idx == IDX_CMD) && !ctrl_rst;
   assign is_rd  = (cmd.op == OP_RD);
   assign is_nop = (cmd.op == OP_NOP);
   assign is_wr  = (cmd.op == OP_WR);

   // ---------------- register bank
   logic [REG_DW-1:0] bank_rdata;
   rfb_reg_bank #(.AW(REG_AW), .DW(REG_DW)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctrl_rst),
      .we    (cmd_we && is_wr),
      .waddr (cmd.reg_no[REG_AW-1:0]),
      .wdata (cmd.data[REG_DW-1:0]),
      .raddr (cmd.reg_no[REG_AW-1:0]),
      .rdata (bank_rdata)
   );

   // ---------------- pending (one-behind) result
   logic [REG_DW-1:0] held_q;
   always_ff @(posedge clk) begin
      if (!rst_n || ctrl_rst)          held_q <= '0;
      else if (cmd_we && is_rd)        held_q <= bank_rdata;
      else if (cmd_we && is_nop)       held_q <= '0;
   end

   // ---------------- data queue
   logic [REG_DW-1:0] fifo_head;
   logic [CW-1:0]     fifo_cnt;
   logic              fifo_full, fifo_empty, pop_req;
   assign pop_req = bus_rd && hit && (idx == IDX_DATA);

   rfb_data_fifo #(.DEPTH(FIFO_DEPTH), .DW(REG_DW)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ctrl_rst),
      .push      (cmd_we && (is_rd || is_nop)),
      .push_data (held_q),
      .pop       (pop_req),
      .head      (fifo_head),
      .count     (fifo_cnt),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   // ---------------- interrupts
   logic [7:0]        src_vec, src_smp;
   logic [ISTS_W-1:0] ists, imsk;
   logic              data_above;

   if (N_ALARM == 7) begin : g_alm_full
      assign src_vec = {overtemp_in, alarm_in};
   end else begin : g_alm_pad
      assign src_vec = {overtemp_in, {(7 - N_ALARM){1'b0}}, alarm_in};
   end

   assign data_above = 4'(fifo_cnt) > cfg_q[19:16];

   rfb_irq_unit #(.N_SRC(8)) irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_raw  (src_vec),
      .lvl_set  ({1'b1, data_above}),
      .clr_we   (bus_wr && hit && idx == IDX_ISTS),
      .clr_bits (bus_wdata[ISTS_W-1:0]),
      .msk_we   (bus_wr && hit && idx == IDX_IMSK),
      .msk_data (bus_wdata[ISTS_W-1:0]),
      .sts      (ists),
      .msk      (imsk),
      .src_smp  (src_smp),
      .irq      (irq)
   );

   // ---------------- registered read mux
   logic [31:0] stat_w, rd_mux;
   assign stat_w = {16'h0, 4'(fifo_cnt), 1'b0, 1'b1, fifo_full, fifo_empty, src_smp};

   always_comb begin
      rd_mux = '0;
      if (hit) begin
         case (idx)
            IDX_CFG:  rd_mux = cfg_q;
            IDX_ISTS: rd_mux = 32'(ists);
            IDX_IMSK: rd_mux = 32'(imsk);
            IDX_STAT: rd_mux = stat_w;
            IDX_DATA: rd_mux = fifo_empty ? '0 : 32'(fifo_head);
            IDX_CTRL: rd_mux = 32'(ctrl_rst) << CTRL_RST_BIT;
            default:  rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/rfb_checker.sv
`timescale 1ns/1ps
module rfb_checker #(
   parameter int ADDR_W = 5,
   parameter int DEPTH  = 15,
   parameter int CW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              wdata_b9,
   input logic              bus_rd,
   input logic [31:0]       bus_rdata,
   input logic              irq,
   input logic [CW-1:0]     fifo_cnt,
   input logic              ctrl_rst,
   input logic [9:0]        ists
);
   logic at_cmd, at_stat, at_ists;
   assign at_cmd  = (32'(bus_addr) == 32'h10);
   assign at_stat = (32'(bus_addr) == 32'h0C);
   assign at_ists = (32'(bus_addr) == 32'h04);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fifo_cnt) <= DEPTH);

   // R11
   chan_reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rst |=> fifo_cnt == '0);

   // R9
   cmd_low_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ists[9] && !(bus_wr && at_ists && wdata_b9)) |=> ists[9]);

   // R12
   wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && at_cmd) |=> bus_rdata == 32'h0);

   // R6
   cmd_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && at_stat) |=> (bus_rdata[10] && !bus_rdata[11]));

   // R7
   quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ists == '0) |-> !irq);
endmodule

bind regbank_fifo_bridge rfb_checker #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CW(CW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .wdata_b9  (bus_wdata[9]),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .fifo_cnt  (fifo_cnt),
   .ctrl_rst  (ctrl_rst),
   .ists      (ists)
);

// File: tb/regbank_fifo_bridge_tb_top.sv
`timescale 1ns/1ps
module regbank_fifo_bridge_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  alarm_in = '0;
   logic        overtemp_in = 1'b0;
   logic        irq;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   regbank_fifo_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .alarm_in(alarm_in), .overtemp_in(overtemp_in), .irq(irq));

   localparam logic [4:0] A_CFG = 5'h00, A_ISTS = 5'h04, A_IMSK = 5'h08, A_STAT = 5'h0C,
                          A_CMD = 5'h10, A_DATA = 5'h14, A_CTRL = 5'h18, A_GAP = 5'h1C;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] mk_cmd(input logic [3:0] op, input logic [6:0] r, input logic [15:0] d);
      return {2'b00, op, 3'b000, r, d};
   endfunction

   function automatic logic [15:0] patv(input int i);
      return 16'(i * 291) ^ 16'hA55A;
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      logic [15:0] held;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // reset values, registered read (R1, R13)
      chk("R1 irq at reset", 32'(irq), 32'h0);
      rd(A_CFG, v);  chk("R1 R13 cfg reset", v, 32'h0000_1114);
      rd(A_ISTS, v); chk("R1 ists reset", v, 32'h200);
      rd(A_IMSK, v); chk("R1 mask reset", v, 32'h3FF);
      rd(A_STAT, v); chk("R1 status reset", v, 32'h500);
      rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h10);

      // commands ignored in channel reset (R11)
      wr(A_CMD, mk_cmd(4'd2, 7'd6, 16'h1234));
      wr(A_CMD, mk_cmd(4'd1, 7'd6, 16'h0));
      rd(A_STAT, v); chk("R11 no push in reset", v, 32'h500);
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, v); chk("R11 ctrl released", v, 32'h0);
      wr(A_CMD, mk_cmd(4'd1, 7'd6, 16'h0));
      wr(A_CMD, mk_cmd(4'd0, 7'd0, 16'h0));
      rd(A_DATA, v); chk("R11 held zero", v, 32'h0);
      rd(A_DATA, v); chk("R11 write ignored in reset", v, 32'h0);

      // write then hold reset: bank, queue, held cleared (R11, R4)
      wr(A_CMD, mk_cmd(4'd2, 7'd5, 16'hABCD));
      wr(A_CMD, mk_cmd(4'd1, 7'd5, 16'h0));
      wr(A_CMD, mk_cmd(4'd1, 7'd5, 16'h0));
      rd(A_STAT, v); chk("R4 two pushes", v, 32'h2400);
      rd(A_DATA, v); chk("R4 first pop is earlier result", v, 32'h0);
      rd(A_DATA, v); chk("R4 second pop lags one", v, 32'hABCD);
      wr(A_CMD, mk_cmd(4'd0, 7'd0, 16'h0));   // queue 1 entry (ABCD), held 0
      wr(A_CMD, mk_cmd(4'd1, 7'd5, 16'h0));   // queue 2, held ABCD
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, v); chk("R11 only bit4 kept", v, 32'h10);
      rd(A_STAT, v); chk("R11 queue cleared", v, 32'h500);
      wr(A_CTRL, 32'h0);
      wr(A_CMD, mk_cmd(4'd1, 7'd5, 16'h0));
      wr(A_CMD, mk_cmd(4'd0, 7'd0, 16'h0));
      rd(A_DATA, v); chk("R11 held cleared", v, 32'h0);
      rd(A_DATA, v); chk("R11 bank cleared", v, 32'h0);
      held = 16'h0;

      // full bank sweep (R3, R4)
      for (int i = 0; i < 128; i++) wr(A_CMD, mk_cmd(4'd2, 7'(i), patv(i)));
      for (int i = 0; i < 128; i++) begin
         wr(A_CMD, mk_cmd(4'd1, 7'(i), 16'h0));
         rd(A_DATA, v);
         chk($sformatf("R3 R4 sweep reg %0d", i), v, 32'(held));
         held = patv(i);
      end

      // unknown opcodes (R3)
      for (int op = 3; op < 16; op++) wr(A_CMD, mk_cmd(4'(op), 7'd9, 16'h2222));
      rd(A_STAT, v); chk("R3 unknown op no push", v, 32'h500);
      wr(A_CMD, mk_cmd(4'd1, 7'd9, 16'h0));
      wr(A_CMD, mk_cmd(4'd0, 7'd0, 16'h0));
      rd(A_DATA, v); chk("R3 pending result", v, 32'(held));
      rd(A_DATA, v); chk("R3 unknown op bank kept", v, 32'(patv(9)));
      held = 16'h0;

      // fill past capacity (R5, R6)
      wr(A_CMD, mk_cmd(4'd1, 7'd20, 16'h0));   // queue [0], held patv(20)
      for (int k = 0; k < 19; k++) wr(A_CMD, mk_cmd(4'd0, 7'd0, 16'h0));
      rd(A_STAT, v); chk("R5 R6 full status", v, 32'hF600);
      for (int k = 0; k < 15; k++) begin
         rd(A_DATA, v);
         chk($sformatf("R5 drain %0d", k), v, (k == 1) ? 32'(patv(20)) : 32'h0);
      end
      rd(A_STAT, v); chk("R5 R6 drained", v, 32'h500);
      rd(A_DATA, v); chk("R5 empty pop zero", v, 32'h0);
      rd(A_STAT, v); chk("R5 count stays zero", v, 32'h500);

      // data-above threshold (R8, R2)
      wr(A_CFG, 32'h0002_1114);
      wr(A_ISTS, 32'h3FF);
      wr(A_CMD, mk_cmd(4'd0, 7'd0, 16'h0));
      wr(A_CMD, mk_cmd(4'd0, 7'd0, 16'h0));
      idle(1);
      rd(A_ISTS, v); chk("R8 count 2 not above 2", v, 32'h200);
      wr(A_CMD, mk_cmd(4'd0, 7'd0, 16'h0));
      idle(1);
      rd(A_ISTS, v); chk("R8 count 3 above 2", v, 32'h300);
      wr(A_ISTS, 32'h100);
      rd(A_ISTS, v); chk("R8 cleared first cycle", v, 32'h200);
      rd(A_ISTS, v); chk("R8 reasserts", v, 32'h300);
      for (int k = 0; k < 3; k++) rd(A_DATA, v);
      idle(1);
      wr(A_ISTS, 32'h3FF);
      rd(A_ISTS, v); chk("R9 cleared first cycle", v, 32'h000);
      rd(A_ISTS, v); chk("R9 R8 reasserts alone", v, 32'h200);

      // mask and irq (R7)
      wr(A_IMSK, 32'hFFFF_FDFF);
      rd(A_IMSK, v); chk("R7 mask width", v, 32'h1FF);
      chk("R7 irq unmasked", 32'(irq), 32'h1);
      wr(A_IMSK, 32'hFFFF_FFFF);
      chk("R7 irq masked", 32'(irq), 32'h0);

      // alarms (R10, R6)
      alarm_in = 7'b000_1000;
      idle(2);
      rd(A_ISTS, v); chk("R10 alarm3 edge", v, 32'h208);
      rd(A_STAT, v); chk("R6 R10 alarm level", v, 32'h508);
      wr(A_ISTS, 32'h8);
      idle(1);
      rd(A_ISTS, v); chk("R10 held high no reset", v, 32'h200);
      alarm_in = 7'b0;
      idle(1);
      overtemp_in = 1'b1;
      idle(2);
      rd(A_ISTS, v); chk("R10 overtemp edge", v, 32'h280);
      rd(A_STAT, v); chk("R6 R10 overtemp level", v, 32'h580);
      wr(A_IMSK, 32'h37F);
      chk("R7 irq on overtemp", 32'(irq), 32'h1);
      overtemp_in = 1'b0;
      wr(A_IMSK, 32'h3FF);
      wr(A_ISTS, 32'h3FF);

      // access rules (R12, R2)
      wr(A_STAT, 32'hFFFF_FFFF);
      wr(A_DATA, 32'hFFFF_FFFF);
      wr(A_GAP, 32'hFFFF_FFFF);
      wr(5'h01, 32'hFFFF_FFFF);
      rd(A_STAT, v); chk("R12 status not writable", v, 32'h500);
      rd(A_CFG, v);  chk("R12 cfg untouched", v, 32'h0002_1114);
      rd(A_CMD, v);  chk("R12 cmd reads zero", v, 32'h0);
      rd(A_GAP, v);  chk("R12 unmapped reads zero", v, 32'h0);
      rd(5'h02, v);  chk("R12 misaligned reads zero", v, 32'h0);
      wr(A_CFG, 32'hFFFF_FFFF);
      rd(A_CFG, v);  chk("R2 cfg kept bits", v, 32'h80FF_331F);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule